// File: doc/BRIEF.md
# Zero-crossing triggered half-pulse modulator

This block is the digital core of a single-mode minimum-deviation controller for a buck-type power stage. In steady state it runs a plain PWM: a free-running period counter is compared against a held duty word. The duty word comes from an external voltage compensator. The result drives complementary high-side and low-side gate enables, with a one-clock dead gap between them.

When a load transient occurs, an external comparator reports the sign of the output capacitor current on a single input. A rising edge on that input means the current has crossed zero going positive. The block then forces the high-side switch on for half of the pre-transient on-time. A falling edge forces the switch off for half of the pre-transient off-time.

Each corrective pulse is timed by its own set/reset timer. The only information used is the duty value held from before the transient; no converter parameters enter. There is a single operating mode, so back-to-back transients need no mode-change handling.

Top module: `zc_half_pulse_mod`

## Requirements
- R1: While `rst_ni` is low, both `hs_en_o` and `ls_en_o` are 0.
- R2: In steady state the period is T = 2^PER_W clocks. Gate demand is high for the first K = (D·T)>>DUTY_W counts of each period, where D is the held duty. At the ports this gives `hs_en_o` high for K−1 consecutive clocks and `ls_en_o` high for T−K−1 consecutive clocks. With D = 0, `hs_en_o` never goes high.
- R3: A rising edge on `zc_i`, taken after a two-flop synchronizer, starts an on pulse. The pulse holds gate demand high for (D·T)>>(DUTY_W+1) clocks. When the pulse starts from the low-side phase, `hs_en_o` is high for one clock fewer than that.
- R4: A falling edge on `zc_i` starts an off pulse. The pulse holds gate demand low for ((2^DUTY_W−D)·T)>>(DUTY_W+1) clocks. When the pulse starts from the high-side phase, `ls_en_o` is high for one clock fewer than that.
- R5: `duty_i` is copied into the held duty only on the last count of a period, and only when no corrective pulse is active. A change on `duty_i` in the middle of a period therefore does not alter a pulse triggered in that period.
- R6: While either corrective pulse is active, further edges on `zc_i` are ignored. An active pulse is never shortened or restarted.
- R7: `hs_en_o` and `ls_en_o` are never 1 in the same clock.
- R8: Every switch from one gate to the other passes through at least one clock in which both gates are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| duty_i | input | DUTY_W | Duty command, unsigned fraction of 2^DUTY_W |
| zc_i | input | 1 | Capacitor current sign from comparator, asynchronous |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
A corrective pulse can only be seen at the ports when it falls entirely inside a steady-state phase of the opposite sense. Otherwise it merges with the PWM drive and its width cannot be read. The stimulus therefore locks onto the observed gate edges. An on pulse is triggered a few clocks after the high-side gate drops, and an off pulse a few clocks after it rises. Duty values are chosen so that the pulse finishes before the next period boundary. Ignoring edges while busy and the frozen duty are shown by changing `zc_i` or `duty_i` inside that same window and confirming that the measured width is unchanged.

// File: rtl/zc_hp_pkg.sv
package zc_hp_pkg;
  typedef enum logic [1:0] {
    GATE_OFF = 2'd0,
    GATE_HI  = 2'd1,
    GATE_LO  = 2'd2
  } gate_state_e;

  localparam int unsigned PULSE_ON  = 0;
  localparam int unsigned PULSE_OFF = 1;
  localparam int unsigned NUM_PULSE = 2;
endpackage

// File: rtl/zc_hp_sync.sv
module zc_hp_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], async_i};
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/zc_hp_timer.sv
module zc_hp_timer #(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o
);
  logic             act_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      ref_q <= '0;
    end else if (act_q) begin
      if (cnt_q == ref_q) act_q <= 1'b0;
      else                cnt_q <= cnt_q + LEN_W'(1);
    end else if (trig_i && (len_i != '0)) begin
      act_q <= 1'b1;
      cnt_q <= LEN_W'(1);
      ref_q <= len_i;
    end
  end

  assign active_o = act_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q != '0) && (cnt_q <= ref_q)); // R3
  AST_NO_RETRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> !trig_i); // R6
endmodule

// File: rtl/zc_hp_pwm.sv
module zc_hp_pwm #(
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned PER_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              busy_i,
  output logic              pwm_hi_o,
  output logic [PER_W-1:0]  on_len_o,
  output logic [PER_W-1:0]  off_len_o
);
  localparam int unsigned SH_FULL = DUTY_W - PER_W;
  localparam int unsigned SH_HALF = SH_FULL + 1;

  logic [PER_W-1:0]  cnt_q;
  logic [DUTY_W-1:0] hold_q;
  logic [DUTY_W:0]   comp;
  logic [PER_W-1:0]  full_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
      if ((&cnt_q) && !busy_i) hold_q <= duty_i;
    end
  end

  // lengths = T*D >> DUTY_W (full) and >> DUTY_W+1 (half), T = 2^PER_W
  assign comp      = {1'b1, {DUTY_W{1'b0}}} - {1'b0, hold_q};
  assign full_len  = PER_W'(hold_q >> SH_FULL);
  assign on_len_o  = PER_W'(hold_q >> SH_HALF);
  assign off_len_o = PER_W'(comp >> SH_HALF);
  assign pwm_hi_o  = cnt_q < full_len;

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> $stable(hold_q)); // R5
endmodule

// File: rtl/zc_hp_gate.sv
module zc_hp_gate
  import zc_hp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic demand_i,
  output logic hs_o,
  output logic ls_o
);
  gate_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (demand_i) st_d = (st_q == GATE_LO) ? GATE_OFF : GATE_HI;
    else          st_d = (st_q == GATE_HI) ? GATE_OFF : GATE_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= GATE_OFF;
    else         st_q <= st_d;
  end

  assign hs_o = (st_q == GATE_HI);
  assign ls_o = (st_q == GATE_LO);

  AST_DEAD_GAP_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !$past(ls_o)); // R8
  AST_DEAD_GAP_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> !$past(hs_o)); // R8
endmodule

// File: rtl/zc_half_pulse_mod.sv
module zc_half_pulse_mod
  import zc_hp_pkg::*;
#(
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned PER_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              zc_i,
  output logic              hs_en_o,
  output logic              ls_en_o
);
  logic zc_rise, zc_fall, busy, pwm_hi, demand;
  logic [NUM_PULSE-1:0]  trig, act;
  logic [PER_W-1:0]      len [NUM_PULSE];

  zc_hp_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(zc_i),
    .rise_o (zc_rise),
    .fall_o (zc_fall)
  );

  assign busy            = |act;
  assign trig[PULSE_ON]  = zc_rise & ~busy;
  assign trig[PULSE_OFF] = zc_fall & ~busy;

  zc_hp_pwm #(.DUTY_W(DUTY_W), .PER_W(PER_W)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .duty_i   (duty_i),
    .busy_i   (busy),
    .pwm_hi_o (pwm_hi),
    .on_len_o (len[PULSE_ON]),
    .off_len_o(len[PULSE_OFF])
  );

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_timer
    zc_hp_timer #(.LEN_W(PER_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig[g]),
      .len_i   (len[g]),
      .active_o(act[g])
    );
  end

  // corrective pulse overrides the steady PWM
  always_comb begin
    if (act[PULSE_ON])       demand = 1'b1;
    else if (act[PULSE_OFF]) demand = 1'b0;
    else                     demand = pwm_hi;
  end

  zc_hp_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .demand_i(demand),
    .hs_o    (hs_en_o),
    .ls_o    (ls_en_o)
  );

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o)); // R7
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act)); // R6
  AST_RST_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> !hs_en_o && !ls_en_o); // R1
endmodule

// File: tb/zc_half_pulse_mod_tb.sv
module zc_half_pulse_mod_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int PW = 6;
  localparam int T  = 1 << PW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DW-1:0] duty = '0;
  logic zc = 1'b0;
  logic hs, ls;

  int n_chk = 0;
  int n_fail = 0;
  int n_overlap = 0;
  int n_gap = 0;
  bit prev_hs = 0, prev_ls = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_half_pulse_mod #(.DUTY_W(DW), .PER_W(PW)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .duty_i (duty),
    .zc_i   (zc),
    .hs_en_o(hs),
    .ls_en_o(ls)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (hs && ls) n_overlap++;
      if ((hs && !prev_hs && prev_ls) || (ls && !prev_ls && prev_hs)) n_gap++;
    end
    prev_hs = hs;
    prev_ls = ls;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_len(input bit use_ls, output int len);
    int guard = 0;
    len = 0;
    while ((use_ls ? ls : hs) == 1'b0 && guard < 400) begin cyc(1); guard++; end
    while ((use_ls ? ls : hs) == 1'b1 && guard < 400) begin len++; cyc(1); guard++; end
  endtask

  task automatic wait_hs_fall();
    int guard = 0;
    while (!hs && guard < 400) begin cyc(1); guard++; end
    while (hs && guard < 400) begin cyc(1); guard++; end
  endtask

  task automatic wait_hs_rise();
    int guard = 0;
    while (hs && guard < 400) begin cyc(1); guard++; end
    while (!hs && guard < 400) begin cyc(1); guard++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int len, hcnt;
    cyc(3);
    check("R1 hs in reset", int'(hs), 0);
    check("R1 ls in reset", int'(ls), 0);
    rst_ni = 1'b1;

    // R2 zero duty: never high-side
    cyc(2 * T);
    hcnt = 0;
    for (int i = 0; i < 2 * T + 2; i++) begin cyc(1); if (hs) hcnt++; end
    check("R2 D=0 hs count", hcnt, 0);

    // R2 steady PWM sweep
    for (int d = 32; d <= 192; d += 32) begin
      duty = DW'(d);
      cyc(3 * T);
      wait_hs_fall();
      run_len(1'b1, len);
      check("R2 ls run", len, T - (d * T >> DW) - 1);
      run_len(1'b0, len);
      check("R2 hs run", len, (d * T >> DW) - 1);
    end

    // R3 on pulse, triggered in low-side phase
    for (int d = 16; d <= 128; d += 16) begin
      duty = DW'(d);
      cyc(3 * T);
      wait_hs_fall();
      cyc(2);
      zc = 1'b1;
      run_len(1'b0, len);
      check("R3 on pulse hs run", len, (d * T >> (DW + 1)) - 1);
      zc = 1'b0;
      cyc(2 * T);
    end

    // R4 off pulse, triggered in high-side phase
    for (int d = 160; d <= 224; d += 32) begin
      duty = DW'(d);
      cyc(3 * T);
      wait_hs_fall();
      cyc(2);
      zc = 1'b1;
      cyc(2 * T);
      wait_hs_rise();
      cyc(2);
      zc = 1'b0;
      run_len(1'b1, len);
      check("R4 off pulse ls run", len, (((1 << DW) - d) * T >> (DW + 1)) - 1);
      cyc(2 * T);
    end

    // R5 mid-period duty change does not alter the pulse
    duty = 8'd128;
    cyc(3 * T);
    wait_hs_fall();
    duty = 8'd32;
    cyc(2);
    zc = 1'b1;
    run_len(1'b0, len);
    check("R5 held duty used", len, (128 * T >> (DW + 1)) - 1);
    zc = 1'b0;
    duty = 8'd128;
    cyc(3 * T);

    // R6 falling edge during active on pulse is ignored
    wait_hs_fall();
    cyc(2);
    zc = 1'b1;
    begin
      int guard = 0;
      while (!hs && guard < 400) begin cyc(1); guard++; end
      len = 0;
      cyc(2);
      len = 2;
      zc = 1'b0;
      while (hs && guard < 400) begin len++; cyc(1); guard++; end
    end
    check("R6 ignored edge", len, (128 * T >> (DW + 1)) - 1);
    cyc(2 * T);

    check("R7 overlap count", n_overlap, 0);
    check("R8 gap violations", n_gap, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule